// File: doc/BRIEF.md
# Configurable Parallel Host Port

This block is a slave port through which an external host and an internal processor exchange 16-bit words over an 8-bit host bus. The host reaches one data location and one read-only status byte by means of a status-select pin and a byte-select pin. Host writes fill an input word register that the processor reads. Host reads drain an output word register that the processor writes. Two flags, input-full and output-empty, track the hand-off. They appear on two host pins, in a status byte, and as one-cycle interrupt pulses on the internal side.

A control register picks the transfer width (one byte or a full word), the strobe scheme (a separate write strobe and read strobe, or a direction pin plus one data strobe of programmable polarity), which byte a 1 on byte-select addresses, whether the flag pins are inverted, and whether both flags are ORed onto the input-full pin. Host pins are brought through a synchronizer. A host access takes effect on the trailing edge of its strobe, using the address and data held during the strobe.

Top module: `host_port`

## Requirements
- R1: After synchronous reset, input-full is 0, output-empty is 1, the control register is 0, pin_ibf is 0 and pin_obe is 1. Internal address 3 returns {output-empty, input-full} in bits [1:0], and address 2 returns the control register.
- R2: With control bit 1 clear, h_sa is an active-low write strobe and h_sb is an active-low read strobe. An access completes when its strobe returns high.
- R3: With control bit 1 set, h_sa gives the direction (1 read, 0 write) and h_sb is the data strobe. The strobe is active-high when control bit 2 is set and active-low otherwise.
- R4: In word mode (control bit 0 set) with h_stat low, h_bsel equal to control bit 3 addresses the low byte and the other value addresses the high byte.
- R5: In byte mode with h_stat low, only h_bsel equal to control bit 3 is valid and addresses the low byte. The other combination is reserved: it changes no flag, and a write to it leaves the input register unchanged.
- R6: With h_stat high, h_bsel equal to control bit 3 reads the status byte {6'b0, output-empty, input-full}. The other combination is reserved. No status access changes any flag.
- R7: In word mode the flags change only once both bytes have moved, in either order. A completed host write places the assembled word in the input register.
- R8: In byte mode every low-byte host write sets input-full and loads {8'h00, byte} into the input register. Every low-byte host read sets output-empty.
- R9: An internal read of address 0 clears input-full. An internal write of address 1 loads the output register and clears output-empty. A host completion in the same cycle wins.
- R10: With control bit 4 set, both flag pins are driven inverted.
- R11: With control bit 5 set, pin_ibf carries the OR of both flags (before inversion), and pin_obe is unchanged.
- R12: irq_ibf and irq_obe each pulse high for one cycle whenever their flag is set by a host completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_sa | input | 1 | Write strobe, or direction pin in strobe scheme 1 |
| h_sb | input | 1 | Read strobe, or data strobe in strobe scheme 1 |
| h_stat | input | 1 | Selects the status byte when high |
| h_bsel | input | 1 | Byte select |
| h_din | input | BYTE_W | Host write data |
| h_dout | output | BYTE_W | Host read data (registered) |
| pin_ibf | output | 1 | Input-full pin, optionally merged and inverted |
| pin_obe | output | 1 | Output-empty pin, optionally inverted |
| i_addr | input | 2 | Internal address: 0 input, 1 output, 2 control, 3 status |
| i_wr | input | 1 | Internal write |
| i_rd | input | 1 | Internal read |
| i_wdata | input | 2*BYTE_W | Internal write data |
| i_rdata | output | 2*BYTE_W | Internal read data, valid the cycle after i_rd |
| irq_ibf | output | 1 | Input-full interrupt pulse |
| irq_obe | output | 1 | Output-empty interrupt pulse |

## Verification
The bench sweeps all sixteen combinations of width, strobe scheme, strobe polarity and byte-select meaning. In each one it hits the reserved status and data combinations, which must leave both flags untouched. A decoder that let those through would raise a flag early or corrupt the input word. In word mode the high byte is written before the low byte, and the status is checked between the two bytes, so a block that flagged after the first byte or assembled bytes by arrival order fails. A final pass walks flag inversion and merging over two opposite flag states. That catches a merge placed on the wrong pin or an inversion that skips one pin.

// File: rtl/host_port_pkg.sv
package host_port_pkg;

  // control register layout, msb first; bit 0 is wide
  typedef struct packed {
    logic merge;    // bit 5
    logic inv;      // bit 4
    logic swap;     // bit 3
    logic strb_hi;  // bit 2
    logic style;    // bit 1
    logic wide;     // bit 0
  } cfg_t;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_LO   = 2'd1,
    TGT_HI   = 2'd2,
    TGT_STAT = 2'd3
  } tgt_e;

  localparam logic [1:0] ADDR_IN   = 2'd0;
  localparam logic [1:0] ADDR_OUT  = 2'd1;
  localparam logic [1:0] ADDR_CFG  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  function automatic tgt_e map_target(input logic wide, input logic swap,
                                      input logic stat, input logic bsel);
    if (stat)
      return (bsel == swap) ? TGT_STAT : TGT_NONE;
    if (bsel == swap)
      return TGT_LO;
    return wide ? TGT_HI : TGT_NONE;
  endfunction

endpackage

// File: rtl/host_port_sync.sv
module host_port_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)
        pipe[g] <= RST_VAL;
      else if (g == 0)
        pipe[g] <= d;
      else
        pipe[g] <= pipe[(g == 0) ? 0 : g-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/host_port_strobe.sv
module host_port_strobe
  import host_port_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cfg_t cfg,
  input  logic cfg_we,
  input  logic sa,
  input  logic sb,
  output logic wr_ev,
  output logic rd_ev
);
  logic ds_act, wr_now, rd_now, wr_prev, rd_prev;

  assign ds_act = (sb == cfg.strb_hi);
  assign wr_now = cfg.style ? (ds_act && !sa) : !sa;
  assign rd_now = cfg.style ? (ds_act && sa)  : !sb;

  // a control write forgets strobe history so a re-interpreted pin
  // level can never look like a trailing edge
  always_ff @(posedge clk) begin
    if (rst || cfg_we) begin
      wr_prev <= 1'b0;
      rd_prev <= 1'b0;
    end else begin
      wr_prev <= wr_now;
      rd_prev <= rd_now;
    end
  end

  assign wr_ev = wr_prev && !wr_now && !cfg_we;
  assign rd_ev = rd_prev && !rd_now && !cfg_we;
endmodule

// File: rtl/host_port.sv
module host_port
  import host_port_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                h_sa,
  input  logic                h_sb,
  input  logic                h_stat,
  input  logic                h_bsel,
  input  logic [BYTE_W-1:0]   h_din,
  output logic [BYTE_W-1:0]   h_dout,
  output logic                pin_ibf,
  output logic                pin_obe,
  input  logic [1:0]          i_addr,
  input  logic                i_wr,
  input  logic                i_rd,
  input  logic [2*BYTE_W-1:0] i_wdata,
  output logic [2*BYTE_W-1:0] i_rdata,
  output logic                irq_ibf,
  output logic                irq_obe
);
  localparam int WORD_W = 2*BYTE_W;
  localparam int BUS_W  = BYTE_W + 4;
  localparam int CFG_W  = $bits(cfg_t);
  localparam logic [BUS_W-1:0] BUS_RST = {2'b11, {(BUS_W-2){1'b0}}};

  cfg_t              cfg_q;
  logic              ibf_q, obe_q;
  logic [WORD_W-1:0] in_q, out_q;
  logic [BYTE_W-1:0] lo_sh, hi_sh;
  logic              w_lo_seen, w_hi_seen, r_lo_seen, r_hi_seen;

  logic [BUS_W-1:0]  sy;
  logic              sy_sa, sy_sb, sy_stat, sy_bsel;
  logic [BYTE_W-1:0] sy_din;
  logic              p_stat, p_bsel;
  logic [BYTE_W-1:0] p_din;

  logic              cfg_we, int_rd_in, int_wr_out;
  logic              wr_ev, rd_ev, ev_any, ev_quiet;
  tgt_e              tgt_now, tgt_ev;
  logic              wr_lo, wr_hi, rd_lo, rd_hi, wr_done, rd_done;
  logic [BYTE_W-1:0] asm_lo, asm_hi;

  host_port_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) u_sync (
    .clk(clk), .rst(rst),
    .d({h_sa, h_sb, h_stat, h_bsel, h_din}),
    .q(sy)
  );
  assign {sy_sa, sy_sb, sy_stat, sy_bsel, sy_din} = sy;

  assign cfg_we     = i_wr && (i_addr == ADDR_CFG);
  assign int_wr_out = i_wr && (i_addr == ADDR_OUT);
  assign int_rd_in  = i_rd && (i_addr == ADDR_IN);

  host_port_strobe u_strobe (
    .clk(clk), .rst(rst), .cfg(cfg_q), .cfg_we(cfg_we),
    .sa(sy_sa), .sb(sy_sb), .wr_ev(wr_ev), .rd_ev(rd_ev)
  );

  // address and data as held during the strobe that just ended
  always_ff @(posedge clk) begin
    if (rst) begin
      p_stat <= 1'b0;
      p_bsel <= 1'b0;
      p_din  <= '0;
    end else begin
      p_stat <= sy_stat;
      p_bsel <= sy_bsel;
      p_din  <= sy_din;
    end
  end

  assign tgt_now = map_target(cfg_q.wide, cfg_q.swap, sy_stat, sy_bsel);
  assign tgt_ev  = map_target(cfg_q.wide, cfg_q.swap, p_stat, p_bsel);
  assign ev_any   = wr_ev || rd_ev;
  assign ev_quiet = (tgt_ev == TGT_NONE) || (tgt_ev == TGT_STAT);

  assign wr_lo = wr_ev && (tgt_ev == TGT_LO);
  assign wr_hi = wr_ev && (tgt_ev == TGT_HI);
  assign rd_lo = rd_ev && (tgt_ev == TGT_LO);
  assign rd_hi = rd_ev && (tgt_ev == TGT_HI);

  assign wr_done = cfg_q.wide ? ((wr_lo && w_hi_seen) || (wr_hi && w_lo_seen)) : wr_lo;
  assign rd_done = cfg_q.wide ? ((rd_lo && r_hi_seen) || (rd_hi && r_lo_seen)) : rd_lo;

  assign asm_lo = wr_lo ? p_din : lo_sh;
  assign asm_hi = wr_hi ? p_din : hi_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      out_q     <= '0;
      in_q      <= '0;
      lo_sh     <= '0;
      hi_sh     <= '0;
      w_lo_seen <= 1'b0;
      w_hi_seen <= 1'b0;
      r_lo_seen <= 1'b0;
      r_hi_seen <= 1'b0;
      ibf_q     <= 1'b0;
      obe_q     <= 1'b1;
      irq_ibf   <= 1'b0;
      irq_obe   <= 1'b0;
    end else begin
      if (cfg_we)
        cfg_q <= cfg_t'(i_wdata[CFG_W-1:0]);
      if (int_wr_out)
        out_q <= i_wdata;

      if (cfg_we || wr_done) begin
        w_lo_seen <= 1'b0;
        w_hi_seen <= 1'b0;
      end else begin
        if (wr_lo) begin
          w_lo_seen <= 1'b1;
          lo_sh     <= p_din;
        end
        if (wr_hi) begin
          w_hi_seen <= 1'b1;
          hi_sh     <= p_din;
        end
      end

      if (cfg_we || rd_done) begin
        r_lo_seen <= 1'b0;
        r_hi_seen <= 1'b0;
      end else begin
        if (rd_lo) r_lo_seen <= 1'b1;
        if (rd_hi) r_hi_seen <= 1'b1;
      end

      if (wr_done)
        in_q <= cfg_q.wide ? {asm_hi, asm_lo} : {{BYTE_W{1'b0}}, p_din};

      if (wr_done)        ibf_q <= 1'b1;
      else if (int_rd_in) ibf_q <= 1'b0;
      if (rd_done)         obe_q <= 1'b1;
      else if (int_wr_out) obe_q <= 1'b0;

      irq_ibf <= wr_done;
      irq_obe <= rd_done;
    end
  end

  // registered pins and read paths
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_ibf <= 1'b0;
      pin_obe <= 1'b1;
      h_dout  <= '0;
      i_rdata <= '0;
    end else begin
      pin_ibf <= (cfg_q.merge ? (ibf_q || obe_q) : ibf_q) ^ cfg_q.inv;
      pin_obe <= obe_q ^ cfg_q.inv;
      case (tgt_now)
        TGT_LO:   h_dout <= out_q[BYTE_W-1:0];
        TGT_HI:   h_dout <= out_q[WORD_W-1:BYTE_W];
        TGT_STAT: h_dout <= BYTE_W'({obe_q, ibf_q});
        default:  h_dout <= '0;
      endcase
      if (i_rd) begin
        case (i_addr)
          ADDR_IN:  i_rdata <= in_q;
          ADDR_OUT: i_rdata <= out_q;
          ADDR_CFG: i_rdata <= WORD_W'(cfg_q);
          default:  i_rdata <= WORD_W'({obe_q, ibf_q});
        endcase
      end
    end
  end
endmodule

// File: rtl/host_port_chk.sv
module host_port_chk (
  input logic clk,
  input logic rst,
  input logic merge_q,
  input logic inv_q,
  input logic pin_ibf,
  input logic pin_obe,
  input logic irq_ibf,
  input logic irq_obe,
  input logic ibf_q,
  input logic obe_q,
  input logic ev_any,
  input logic ev_quiet,
  input logic int_rd_in,
  input logic int_wr_out,
  input logic rd_done
);
  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!ibf_q && obe_q));

  // R11
  merge_or_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(merge_q && !inv_q) && pin_obe) |-> pin_ibf);

  // R12
  irq_ibf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ibf |=> !irq_ibf);

  // R12
  irq_obe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_obe |=> !irq_obe);

  // R12
  irq_ibf_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ibf |-> ibf_q);

  // R6
  reserved_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_any && ev_quiet && !int_rd_in && !int_wr_out) |=> ($stable(ibf_q) && $stable(obe_q)));

  // R9
  obe_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (int_wr_out && !rd_done) |=> !obe_q);
endmodule

bind host_port host_port_chk u_chk (
  .clk(clk), .rst(rst),
  .merge_q(cfg_q.merge), .inv_q(cfg_q.inv),
  .pin_ibf(pin_ibf), .pin_obe(pin_obe),
  .irq_ibf(irq_ibf), .irq_obe(irq_obe),
  .ibf_q(ibf_q), .obe_q(obe_q),
  .ev_any(ev_any), .ev_quiet(ev_quiet),
  .int_rd_in(int_rd_in), .int_wr_out(int_wr_out),
  .rd_done(rd_done)
);

// File: tb/host_port_bench.sv
module host_port_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_sa = 1'b1, h_sb = 1'b1, h_stat = 1'b0, h_bsel = 1'b0;
  logic [7:0]  h_din = '0;
  logic [7:0]  h_dout;
  logic        pin_ibf, pin_obe;
  logic [1:0]  i_addr = '0;
  logic        i_wr = 1'b0, i_rd = 1'b0;
  logic [15:0] i_wdata = '0;
  logic [15:0] i_rdata;
  logic        irq_ibf, irq_obe;

  int checks = 0;
  int fails = 0;
  int n_irq_ibf = 0;
  int n_irq_obe = 0;
  bit done = 1'b0;
  logic [5:0] cur_cfg = '0;  // [0]wide [1]style [2]strb_hi [3]swap [4]inv [5]merge

  always #(CLK_PERIOD/2) clk = ~clk;

  host_port u_host_port (
    .clk(clk), .rst(rst), .h_sa(h_sa), .h_sb(h_sb), .h_stat(h_stat),
    .h_bsel(h_bsel), .h_din(h_din), .h_dout(h_dout), .pin_ibf(pin_ibf),
    .pin_obe(pin_obe), .i_addr(i_addr), .i_wr(i_wr), .i_rd(i_rd),
    .i_wdata(i_wdata), .i_rdata(i_rdata), .irq_ibf(irq_ibf), .irq_obe(irq_obe)
  );

  always @(posedge clk) begin
    if (irq_ibf) n_irq_ibf <= n_irq_ibf + 1;
    if (irq_obe) n_irq_obe <= n_irq_obe + 1;
  end

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic host_op(input logic is_rd, input logic stat, input logic bsel,
                         input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    h_stat = stat; h_bsel = bsel; h_din = d;
    if (cur_cfg[1]) h_sa = is_rd;
    repeat (2) @(negedge clk);
    if (cur_cfg[1]) h_sb = cur_cfg[2];
    else if (is_rd) h_sb = 1'b0;
    else h_sa = 1'b0;
    repeat (6) @(negedge clk);
    q = h_dout;
    if (cur_cfg[1]) h_sb = ~cur_cfg[2];
    else begin h_sa = 1'b1; h_sb = 1'b1; end
    repeat (6) @(negedge clk);
  endtask

  task automatic stat_rd(output logic [1:0] s);
    logic [7:0] q;
    host_op(1'b1, 1'b1, cur_cfg[3], 8'h00, q);
    s = q[1:0];
  endtask

  task automatic int_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    i_addr = a; i_wdata = d; i_wr = 1'b1;
    @(negedge clk);
    i_wr = 1'b0;
  endtask

  task automatic int_rd(input logic [1:0] a, output logic [15:0] q);
    @(negedge clk);
    i_addr = a; i_rd = 1'b1;
    @(negedge clk);
    i_rd = 1'b0;
    q = i_rdata;
  endtask

  task automatic set_cfg(input logic [5:0] c);
    @(negedge clk);
    h_sa = 1'b1;
    h_sb = (c[1] && c[2]) ? 1'b0 : 1'b1;
    repeat (4) @(negedge clk);
    int_wr(2'd2, {10'd0, c});
    cur_cfg = c;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [15:0] q16;
    logic [7:0]  q8;
    logic [1:0]  s;
    logic [15:0] pat, wb;
    int          ki, ko;
    string       sty;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", "pin_ibf after reset", {15'd0, pin_ibf}, 16'd0);
    chk("R1", "pin_obe after reset", {15'd0, pin_obe}, 16'd1);
    int_rd(2'd3, q16);
    chk("R1", "status after reset", q16, 16'h0002);
    int_rd(2'd2, q16);
    chk("R1", "control after reset", q16, 16'h0000);

    for (int c = 0; c < 16; c++) begin
      set_cfg(6'(c));
      sty = cur_cfg[1] ? "R3" : "R2";
      pat = 16'hA5C3 ^ (16'(c) * 16'h1111);
      wb  = ~pat;
      int_rd(2'd0, q16);
      int_wr(2'd1, pat);
      stat_rd(s);
      chk("R6 R9", "status after clearing", {14'd0, s}, 16'd0);

      // reserved status combination
      host_op(1'b0, 1'b1, ~cur_cfg[3], 8'h5A, q8);
      stat_rd(s);
      chk("R6", "status after reserved status write", {14'd0, s}, 16'd0);
      if (!cur_cfg[0]) begin
        host_op(1'b0, 1'b0, ~cur_cfg[3], 8'h3C, q8);
        host_op(1'b1, 1'b0, ~cur_cfg[3], 8'h00, q8);
        stat_rd(s);
        chk("R5", "status after reserved data accesses", {14'd0, s}, 16'd0);
      end

      ko = n_irq_obe;
      if (cur_cfg[0]) begin
        host_op(1'b1, 1'b0, cur_cfg[3], 8'h00, q8);
        chk({sty, " R4"}, "word low byte read", {8'd0, q8}, {8'd0, pat[7:0]});
        stat_rd(s);
        chk("R7", "obe after one byte", {14'd0, s}, 16'd0);
        host_op(1'b1, 1'b0, ~cur_cfg[3], 8'h00, q8);
        chk({sty, " R4"}, "word high byte read", {8'd0, q8}, {8'd0, pat[15:8]});
        stat_rd(s);
        chk("R7", "obe after both bytes", {14'd0, s}, 16'd2);
      end else begin
        host_op(1'b1, 1'b0, cur_cfg[3], 8'h00, q8);
        chk({sty, " R5"}, "byte read", {8'd0, q8}, {8'd0, pat[7:0]});
        stat_rd(s);
        chk("R8", "obe after byte read", {14'd0, s}, 16'd2);
      end
      chk("R12", "irq_obe pulses", 16'(n_irq_obe - ko), 16'd1);

      ki = n_irq_ibf;
      if (cur_cfg[0]) begin
        host_op(1'b0, 1'b0, ~cur_cfg[3], wb[15:8], q8);
        stat_rd(s);
        chk("R7", "ibf after high byte only", {14'd0, s}, 16'd2);
        host_op(1'b0, 1'b0, cur_cfg[3], wb[7:0], q8);
        stat_rd(s);
        chk("R7", "ibf after both bytes", {14'd0, s}, 16'd3);
        int_rd(2'd0, q16);
        chk({sty, " R4 R7"}, "assembled input word", q16, wb);
      end else begin
        host_op(1'b0, 1'b0, cur_cfg[3], wb[7:0], q8);
        stat_rd(s);
        chk("R8", "ibf after byte write", {14'd0, s}, 16'd3);
        int_rd(2'd0, q16);
        chk({sty, " R8"}, "byte input word", q16, {8'h00, wb[7:0]});
      end
      chk("R12", "irq_ibf pulses", 16'(n_irq_ibf - ki), 16'd1);
      stat_rd(s);
      chk("R9", "ibf cleared by internal read", {14'd0, s}, 16'd2);
      int_wr(2'd1, pat);
      stat_rd(s);
      chk("R9", "obe cleared by internal write", {14'd0, s}, 16'd0);
    end

    // pins: state ibf=1, obe=0
    set_cfg(6'd0);
    host_op(1'b0, 1'b0, 1'b0, 8'h11, q8);
    int_wr(2'd1, 16'h2222);
    for (int m = 0; m < 4; m++) begin
      set_cfg({m[1], m[0], 4'd0});
      repeat (3) @(negedge clk);
      chk("R10 R11", "pin_ibf state A", {15'd0, pin_ibf}, {15'd0, 1'b1 ^ m[0]});
      chk("R10 R11", "pin_obe state A", {15'd0, pin_obe}, {15'd0, 1'b0 ^ m[0]});
    end
    // state ibf=0, obe=1
    set_cfg(6'd0);
    int_rd(2'd0, q16);
    host_op(1'b1, 1'b0, 1'b0, 8'h00, q8);
    for (int m = 0; m < 4; m++) begin
      set_cfg({m[1], m[0], 4'd0});
      repeat (3) @(negedge clk);
      chk("R10 R11", "pin_ibf state B", {15'd0, pin_ibf}, {15'd0, m[1] ^ m[0]});
      chk("R10 R11", "pin_obe state B", {15'd0, pin_obe}, {15'd0, 1'b1 ^ m[0]});
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule